// File: doc/BRIEF.md
# Chained Decimal Digit Adder

This block adds two unsigned decimal numbers held in packed binary-coded-decimal form, one 4-bit digit per decimal place, together with a single decimal carry entering the least significant place. It returns the packed decimal sum and a carry that leaves the most significant place. The logic is purely combinational: results follow the operands with no register in the path.

Each decimal place is handled by one digit cell. The cell first adds its two digits and its incoming carry in plain binary, giving a raw value from 0 to 19. A detection term looks at the raw carry and the upper raw sum bits to decide whether the raw value is ten or more. If it is, a second adder adds six so the digit wraps back into 0 to 9. The detection term is also the cell's decimal carry-out. A parameter sets the number of places, and each cell's carry-out feeds the next cell's carry-in. Operand digits above nine are outside the supported range, and their results are not defined.

Top module: `bcd_chain_adder`

## Requirements
- R1: Within each place, the first stage forms the 5-bit binary value digit_a + digit_b + place carry-in, with bit 4 as the raw carry and bits 3:0 as the raw sum.
- R2: A place's correction flag is raw_carry OR (raw bit 3 AND raw bit 2) OR (raw bit 3 AND raw bit 1). It is high exactly when the raw value is 10 or more. A raw value of 9 leaves it low, and a raw value of 10 sets it.
- R3: The output digit is the raw sum plus 0110 modulo 16 when the flag is high, and the raw sum unchanged when it is low. This equals the raw value minus ten when the raw value is ten or more.
- R4: A place's decimal carry-out equals its correction flag. The carry of the six-adding stage is dropped.
- R5: For operand digits in 0..9, every output digit is in 0..9.
- R6: 8 + 7 with no carry-in gives digit 5 with carry-out 1.
- R7: 9 + 9 gives digit 8 with carry-out 1, and 9 + 9 with carry-in 1 gives digit 9 with carry-out 1.
- R8: carry_in enters place 0. Place k's carry-out is place k+1's carry-in. carry_out is the carry-out of the top place.
- R9: Place k occupies bits [4k+3:4k] of every packed bus, with place 0 (units) at bits 3:0. All-zero operands with carry_in 0 give an all-zero sum and carry_out 0.
- R10: For valid operands, {carry_out, sum_bcd} read as a decimal number equals augend + addend + carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| augend | input | 4*DIGITS | First operand, packed decimal digits, units at bits 3:0 |
| addend | input | 4*DIGITS | Second operand, same packing |
| carry_in | input | 1 | Decimal carry into the units place |
| sum_bcd | output | 4*DIGITS | Packed decimal sum |
| carry_out | output | 1 | Decimal carry out of the top place |

## Verification
There is no register anywhere between the operands and sum_bcd or carry_out. Every result, including a carry that ripples through all places, is therefore due within the same clock period in which the operands change. The bench changes operands on a rising edge of its own clock and samples the outputs at the following falling edge, half a period later, when every level of the digit chain has settled. The checker evaluates each place's raw sum, correction flag and carry link combinationally against the same operands, so it never compares values from different vectors.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  localparam int unsigned NIBBLE_W = 4;
  localparam int unsigned DEC_BASE = 10;

  // one bit of binary addition: sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // one bit of binary addition: carry as generate OR (propagate AND carry)
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | ((x ^ y) & ci);
  endfunction

  // decides whether a raw nibble sum has left the decimal range
  function automatic logic over_nine(input logic c4, input logic [NIBBLE_W-1:0] s);
    return c4 | (s[3] & s[2]) | (s[3] & s[1]);
  endfunction

  // correction operand: 0110 when asked, else zero
  function automatic logic [NIBBLE_W-1:0] six_if(input logic en);
    return {1'b0, en, en, 1'b0};
  endfunction

endpackage

// File: rtl/bcd_ripple_add.sv
module bcd_ripple_add
  import bcd_pkg::*;
#(
  parameter int unsigned WIDTH = NIBBLE_W
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = fa_sum(op_x[i], op_y[i], chain[i]);
    assign chain[i+1] = fa_carry(op_x[i], op_y[i], chain[i]);
  end

  assign cout = chain[WIDTH];

endmodule

// File: rtl/bcd_fix_add.sv
// second stage: adds the correction operand, carry out of the top bit is not built
module bcd_fix_add
  import bcd_pkg::*;
#(
  parameter int unsigned WIDTH = NIBBLE_W
) (
  input  logic [WIDTH-1:0] raw,
  input  logic             fix,
  output logic [WIDTH-1:0] digit
);

  logic [WIDTH-1:0] corr;
  logic [WIDTH-1:0] chain;

  assign corr     = six_if(fix);
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign digit[i] = fa_sum(raw[i], corr[i], chain[i]);
    if (i < WIDTH - 1) begin : g_link
      assign chain[i+1] = fa_carry(raw[i], corr[i], chain[i]);
    end
  end

endmodule

// File: rtl/bcd_fix_detect.sv
module bcd_fix_detect
  import bcd_pkg::*;
(
  input  logic                raw_c4,
  input  logic [NIBBLE_W-1:0] raw_sum,
  output logic                fix
);

  assign fix = over_nine(raw_c4, raw_sum);

endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_pkg::*;
(
  input  logic [NIBBLE_W-1:0] dig_a,
  input  logic [NIBBLE_W-1:0] dig_b,
  input  logic                dcin,
  output logic [NIBBLE_W-1:0] dig_sum,
  output logic                dcout,
  output logic [NIBBLE_W-1:0] raw_sum,
  output logic                raw_c4,
  output logic                fix
);

  bcd_ripple_add #(.WIDTH(NIBBLE_W)) u_stage1 (
    .op_x (dig_a),
    .op_y (dig_b),
    .cin  (dcin),
    .sum  (raw_sum),
    .cout (raw_c4)
  );

  bcd_fix_detect u_detect (
    .raw_c4  (raw_c4),
    .raw_sum (raw_sum),
    .fix     (fix)
  );

  bcd_fix_add #(.WIDTH(NIBBLE_W)) u_stage2 (
    .raw   (raw_sum),
    .fix   (fix),
    .digit (dig_sum)
  );

  assign dcout = fix;

endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic [NIBBLE_W*DIGITS-1:0] augend,
  input  logic [NIBBLE_W*DIGITS-1:0] addend,
  input  logic                       carry_in,
  output logic [NIBBLE_W*DIGITS-1:0] sum_bcd,
  output logic                       carry_out
);

  localparam int unsigned BUS_W = NIBBLE_W * DIGITS;

  // named internal events, observed by the bound checker
  logic [DIGITS:0]   carry_chain;
  logic [BUS_W-1:0]  raw_vec;
  logic [DIGITS-1:0] raw_c4_vec;
  logic [DIGITS-1:0] fix_vec;

  assign carry_chain[0] = carry_in;

  for (genvar k = 0; k < DIGITS; k++) begin : g_place
    bcd_digit_cell u_cell (
      .dig_a   (augend[NIBBLE_W*k +: NIBBLE_W]),
      .dig_b   (addend[NIBBLE_W*k +: NIBBLE_W]),
      .dcin    (carry_chain[k]),
      .dig_sum (sum_bcd[NIBBLE_W*k +: NIBBLE_W]),
      .dcout   (carry_chain[k+1]),
      .raw_sum (raw_vec[NIBBLE_W*k +: NIBBLE_W]),
      .raw_c4  (raw_c4_vec[k]),
      .fix     (fix_vec[k])
    );
  end

  assign carry_out = carry_chain[DIGITS];

endmodule

// File: rtl/bcd_chain_adder_chk.sv
module bcd_chain_adder_chk #(
  parameter int unsigned DIGITS = 4
) (
  input logic [4*DIGITS-1:0] augend,
  input logic [4*DIGITS-1:0] addend,
  input logic                carry_in,
  input logic [4*DIGITS-1:0] sum_bcd,
  input logic                carry_out,
  input logic [DIGITS:0]     carry_chain,
  input logic [4*DIGITS-1:0] raw_vec,
  input logic [DIGITS-1:0]   raw_c4_vec,
  input logic [DIGITS-1:0]   fix_vec
);

  always_comb begin
    a_r8_entry: assert (carry_chain[0] == carry_in);
    a_r8_exit:  assert (carry_out == carry_chain[DIGITS]);
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_chk
    logic [3:0] da, db, ds, rs;
    logic [4:0] rawv;
    assign da   = augend[4*g +: 4];
    assign db   = addend[4*g +: 4];
    assign ds   = sum_bcd[4*g +: 4];
    assign rs   = raw_vec[4*g +: 4];
    assign rawv = {raw_c4_vec[g], rs};

    always_comb begin
      if (da <= 4'd9 && db <= 4'd9) begin
        a_r1_raw_sum:    assert (rawv == ({1'b0, da} + {1'b0, db} + {4'b0, carry_chain[g]}));
        a_r2_fix_iff_ge10: assert (fix_vec[g] == (rawv >= 5'd10));
        a_r3_digit_value: assert (ds == ((rawv >= 5'd10) ? 4'(rawv - 5'd10) : rs));
        a_r4_carry_is_fix: assert (carry_chain[g+1] == fix_vec[g]);
        a_r5_digit_range: assert (ds <= 4'd9);
      end
    end
  end

endmodule

bind bcd_chain_adder bcd_chain_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .augend      (augend),
  .addend      (addend),
  .carry_in    (carry_in),
  .sum_bcd     (sum_bcd),
  .carry_out   (carry_out),
  .carry_chain (carry_chain),
  .raw_vec     (raw_vec),
  .raw_c4_vec  (raw_c4_vec),
  .fix_vec     (fix_vec)
);

// File: tb/bcd_chain_adder_tb.sv
module bcd_chain_adder_tb;

  localparam int ND   = 2;
  localparam int MAXV = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4*ND-1:0] a_bus = '0, b_bus = '0;
  logic cin = 1'b0;
  logic [4*ND-1:0] s_bus;
  logic cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  bcd_chain_adder #(.DIGITS(ND)) u_dut (
    .augend    (a_bus),
    .addend    (b_bus),
    .carry_in  (cin),
    .sum_bcd   (s_bus),
    .carry_out (cout)
  );

  function automatic logic [4*ND-1:0] to_bcd(input int v);
    logic [4*ND-1:0] r;
    int t;
    r = '0;
    t = v;
    for (int k = 0; k < ND; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(input logic [4*ND-1:0] x);
    int r;
    int w;
    r = 0;
    w = 1;
    for (int k = 0; k < ND; k++) begin
      r = r + int'(x[4*k +: 4]) * w;
      w = w * 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit c);
    @(posedge clk);
    a_bus <= to_bcd(a);
    b_bus <= to_bcd(b);
    cin   <= c;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // R9: idle all-zero operands
    check(s_bus == '0, "R9 zero sum", int'(s_bus), 0);
    check(cout == 1'b0, "R9 zero carry", int'(cout), 0);

    // R6: 8+7 -> units 5, carry into tens
    apply(8, 7, 1'b0);
    check(s_bus[3:0] == 4'd5, "R6 digit", int'(s_bus[3:0]), 5);
    check(s_bus[7:4] == 4'd1, "R6 carry", int'(s_bus[7:4]), 1);

    // R7: 9+9 and 9+9+1; R1 raw value 19 is the top of the range
    apply(9, 9, 1'b0);
    check(s_bus[3:0] == 4'd8 && s_bus[7:4] == 4'd1, "R7 9+9", from_bcd(s_bus), 18);
    apply(9, 9, 1'b1);
    check(s_bus[3:0] == 4'd9 && s_bus[7:4] == 4'd1, "R7 R1 9+9+1", from_bcd(s_bus), 19);

    // R2 boundary: raw 9 no correction, raw 10 corrects
    apply(4, 5, 1'b0);
    check(s_bus == to_bcd(9), "R2 raw nine", from_bcd(s_bus), 9);
    apply(5, 5, 1'b0);
    check(s_bus == to_bcd(10), "R2 raw ten", from_bcd(s_bus), 10);

    // R8: carry through every place to carry_out
    apply(99, 0, 1'b1);
    check(cout == 1'b1 && s_bus == '0, "R8 ripple", int'(cout), 1);
    apply(99, 99, 1'b1);
    check(cout == 1'b1 && s_bus == to_bcd(99), "R8 top", from_bcd(s_bus), 99);

    // exhaustive sweep: R3 R4 R5 R8 R9 R10
    for (int a = 0; a < MAXV; a++) begin
      for (int b = 0; b < MAXV; b++) begin
        for (int c = 0; c < 2; c++) begin
          int tot, u, uc, tn;
          apply(a, b, c[0]);
          tot = a + b + c;
          u   = (a % 10) + (b % 10) + c;
          uc  = (u >= 10) ? 1 : 0;
          tn  = (a / 10) + (b / 10) + uc;
          check(from_bcd(s_bus) + (cout ? MAXV : 0) == tot, "R10 total",
                from_bcd(s_bus) + (cout ? MAXV : 0), tot);
          check(s_bus[3:0] <= 4'd9 && s_bus[7:4] <= 4'd9, "R5 range",
                int'(s_bus), int'(to_bcd(tot % MAXV)));
          check(int'(s_bus[3:0]) == u % 10, "R3 units", int'(s_bus[3:0]), u % 10);
          check(int'(s_bus[7:4]) == tn % 10, "R4 R8 tens", int'(s_bus[7:4]), tn % 10);
          check(int'(cout) == ((tn >= 10) ? 1 : 0), "R4 carry_out", int'(cout), (tn >= 10) ? 1 : 0);
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule